// File: doc/BRIEF.md
# Banked Memory Sector Transfer Sequencer

This block is the host-side controller that moves one 128-byte sector between a local byte buffer and an external banked memory board. The board is reached through three byte ports: an address port, a control port, and a data path with separate read and write strobes. A start pulse supplies a 16-bit sector number and a direction. From the sector number the sequencer derives a 5-bit chip number and a 13-bit in-chip byte offset. It loads the chip number and the high offset byte into the board's two address latches using strobe pulses on the control port. It then streams 128 bytes, placing the low address on the address port for every byte.

The state machine has nine named states. `ST_IDLE` moves to `ST_CS_SET` on start. `ST_CS_SET` and `ST_CS_CLR` raise and drop the chip-select latch strobe. `ST_HA_SET` and `ST_HA_CLR` do the same for the high-address latch. From `ST_HA_CLR` a write goes to `ST_WEN`, which turns on write enable with the first low address, and a read goes straight to `ST_BADDR`. `ST_WEN` moves to `ST_BADDR`. `ST_BADDR` presents the low address and moves to `ST_BXFER`. `ST_BXFER` moves one byte; it returns to `ST_BADDR` or, after the last byte, goes to `ST_FINISH`. For a write it stays in `ST_BXFER` until the buffer answers. `ST_FINISH` clears the control port, pulses done and returns to `ST_IDLE`.

On the buffer side, board reads appear as a store pulse carrying an index and a byte. Board writes fetch each byte with a request and index, and the buffer answers with a one-cycle valid.

Top module: `sts_sequencer`

## Requirements
- R1: The chip latch is loaded first. The address port carries sector bits 10..6 (sector / 64, masked to 5 bits) while the control port reads 0x98 (bits 7, 4 and 3 set) for one cycle. The next cycle the control port reads 0x88. Control bits 4 and 5 are never set together.
- R2: The high-address latch is loaded after the chip latch. The address port carries sector bits 5..1 while the control port reads 0xA8 for one cycle. The next cycle the control port reads 0x88.
- R3: Exactly 128 data strobes occur per sector. For strobe k (k = 0..127) the address port holds (L0 + k) mod 256, where L0 is sector bit 0 placed in bit 7. The buffer index is k.
- R4: When dir_write = 0 (read), each byte raises brd_rd for one cycle. In that cycle buf_st is 1, buf_idx = k and buf_wdata equals brd_rdata. Control bit 6 stays clear for the whole transfer.
- R5: When dir_write = 1 (write), the control port goes to 0xC8 with L0 on the address port before the first byte, and it stays 0xC8 through every byte. Each byte asserts buf_req with buf_idx = k and waits for buf_valid. In the buf_valid cycle it raises brd_wr with brd_wdata = buf_rdata.
- R6: After the last byte the control port reads 0x00 while done is 1. done lasts exactly one cycle, and busy is 0 the cycle after.
- R7: A start pulse while busy is 1 is ignored. It does not change the sector in progress, and no second transfer follows.
- R8: After reset the control port is 0x00, busy and done are 0, and there are no strobes, requests or stores.
- R9: The high-address latch is loaded exactly once per sector. The low address wraps modulo 256 and never carries into the high latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a sector transfer (taken only when idle) |
| dir_write | input | 1 | 1 = buffer to board, 0 = board to buffer |
| sector | input | 16 | Sector number |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| brd_addr | output | 8 | Board address port |
| brd_ctrl | output | 8 | Board control port |
| brd_rd | output | 1 | Board read strobe |
| brd_wr | output | 1 | Board write strobe |
| brd_wdata | output | 8 | Byte to board |
| brd_rdata | input | 8 | Byte from board |
| buf_req | output | 1 | Buffer fetch request (write direction) |
| buf_idx | output | 7 | Byte index within the sector |
| buf_valid | input | 1 | Buffer answers a request with buf_rdata |
| buf_rdata | input | 8 | Byte from buffer |
| buf_st | output | 1 | Store pulse to buffer (read direction) |
| buf_wdata | output | 8 | Byte to buffer |

## Verification
The bench targets the sector values whose bit fields sit at the edges. Sector 0 and sector 0xFFFF test the 5-bit masks: a design with the chip number taken from the wrong shift would latch the wrong chip and the board would return bytes from another bank. Odd sectors start the low address at 0x80, which exposes a dropped sector bit 0 or a low address that carries into the high latch. A second high-latch pulse or a wrong address sequence would follow. Write transfers face random buffer latency, so a sequencer that strobes before buf_valid sends stale bytes. A start pulse in the middle of a transfer would retarget or repeat the latch sequence if it were not ignored.

// File: rtl/sts_pkg.sv
package sts_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CS_SET,
        ST_CS_CLR,
        ST_HA_SET,
        ST_HA_CLR,
        ST_WEN,
        ST_BADDR,
        ST_BXFER,
        ST_FINISH
    } sts_state_e;

    localparam int CB_ENABLE = 7;
    localparam int CB_WEN    = 6;
    localparam int CB_HA     = 5;
    localparam int CB_CS     = 4;
    localparam int CB_BSEL   = 3;

    localparam logic [7:0] CTRL_BASE = (8'd1 << CB_ENABLE) | (8'd1 << CB_BSEL);

endpackage

// File: rtl/sts_addr_split.sv
module sts_addr_split #(
    parameter int SEC_W     = 16,
    parameter int CHIP_W    = 5,
    parameter int HI_W      = 5,
    parameter int SEC_BYTES = 128
) (
    input  logic [SEC_W-1:0]  sector,
    output logic [CHIP_W-1:0] chip,
    output logic [HI_W-1:0]   hi,
    output logic [7:0]        lo_start
);
    localparam int SHIFT    = $clog2(SEC_BYTES);
    localparam int CS_SHIFT = HI_W + 8 - SHIFT;

    // chip = sector / sectors-per-chip, high offset = byte address bits above 8
    assign chip     = CHIP_W'(sector >> CS_SHIFT);
    assign hi       = HI_W'(sector >> (8 - SHIFT));
    assign lo_start = 8'(sector << SHIFT);

endmodule

// File: rtl/sts_xfer_ctr.sv
module sts_xfer_ctr #(
    parameter int SEC_BYTES = 128,
    parameter int IDX_W     = $clog2(SEC_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [7:0]       lo_init,
    input  logic             step,
    output logic [7:0]       lo,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo  <= 8'd0;
            idx <= '0;
        end else if (load) begin
            lo  <= lo_init;
            idx <= '0;
        end else if (step) begin
            lo  <= lo + 8'd1;
            idx <= idx + 1'b1;
        end
    end

    assign last = (idx == IDX_W'(SEC_BYTES - 1));

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load && !last |=> idx == $past(idx) + 1'b1); // R3
    AST_LO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load |=> lo == $past(lo) + 8'd1); // R9

endmodule

// File: rtl/sts_sequencer.sv
module sts_sequencer
    import sts_pkg::*;
#(
    parameter int SEC_W     = 16,
    parameter int CHIP_W    = 5,
    parameter int HI_W      = 5,
    parameter int SEC_BYTES = 128,
    parameter int IDX_W     = $clog2(SEC_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dir_write,
    input  logic [SEC_W-1:0] sector,
    output logic             busy,
    output logic             done,
    output logic [7:0]       brd_addr,
    output logic [7:0]       brd_ctrl,
    output logic             brd_rd,
    output logic             brd_wr,
    output logic [7:0]       brd_wdata,
    input  logic [7:0]       brd_rdata,
    output logic             buf_req,
    output logic [IDX_W-1:0] buf_idx,
    input  logic             buf_valid,
    input  logic [7:0]       buf_rdata,
    output logic             buf_st,
    output logic [7:0]       buf_wdata
);
    sts_state_e state, state_nx;

    logic [SEC_W-1:0]  sec_q;
    logic              dir_q;
    logic [CHIP_W-1:0] chip_w;
    logic [HI_W-1:0]   hi_w;
    logic [7:0]        lo0_w;
    logic [7:0]        lo_w;
    logic              last_w;
    logic              step_w;

    sts_addr_split #(
        .SEC_W(SEC_W), .CHIP_W(CHIP_W), .HI_W(HI_W), .SEC_BYTES(SEC_BYTES)
    ) u_split (
        .sector(sec_q), .chip(chip_w), .hi(hi_w), .lo_start(lo0_w)
    );

    sts_xfer_ctr #(.SEC_BYTES(SEC_BYTES), .IDX_W(IDX_W)) u_ctr (
        .clk(clk), .rst_n(rst_n),
        .load(state == ST_HA_CLR), .lo_init(lo0_w),
        .step(step_w), .lo(lo_w), .idx(buf_idx), .last(last_w)
    );

    // one byte completes: reads every transfer cycle, writes on buffer answer
    assign step_w = (state == ST_BXFER) && (!dir_q || buf_valid);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q <= '0;
            dir_q <= 1'b0;
        end else if (state == ST_IDLE && start) begin
            sec_q <= sector;
            dir_q <= dir_write;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_CS_SET;
            ST_CS_SET: state_nx = ST_CS_CLR;
            ST_CS_CLR: state_nx = ST_HA_SET;
            ST_HA_SET: state_nx = ST_HA_CLR;
            ST_HA_CLR: state_nx = dir_q ? ST_WEN : ST_BADDR;
            ST_WEN:    state_nx = ST_BADDR;
            ST_BADDR:  state_nx = ST_BXFER;
            ST_BXFER:  if (step_w) state_nx = last_w ? ST_FINISH : ST_BADDR;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        brd_ctrl  = 8'd0;
        brd_addr  = 8'd0;
        brd_rd    = 1'b0;
        brd_wr    = 1'b0;
        buf_req   = 1'b0;
        buf_st    = 1'b0;
        done      = 1'b0;
        brd_wdata = buf_rdata;
        buf_wdata = brd_rdata;
        unique case (state)
            ST_IDLE: ;
            ST_CS_SET: begin
                brd_ctrl = CTRL_BASE | (8'd1 << CB_CS);
                brd_addr = 8'(chip_w);
            end
            ST_CS_CLR: begin
                brd_ctrl = CTRL_BASE;
                brd_addr = 8'(chip_w);
            end
            ST_HA_SET: begin
                brd_ctrl = CTRL_BASE | (8'd1 << CB_HA);
                brd_addr = 8'(hi_w);
            end
            ST_HA_CLR: begin
                brd_ctrl = CTRL_BASE;
                brd_addr = 8'(hi_w);
            end
            ST_WEN: begin
                brd_ctrl = CTRL_BASE | (8'd1 << CB_WEN);
                brd_addr = lo_w;
            end
            ST_BADDR: begin
                brd_ctrl = CTRL_BASE | (8'(dir_q) << CB_WEN);
                brd_addr = lo_w;
            end
            ST_BXFER: begin
                brd_ctrl = CTRL_BASE | (8'(dir_q) << CB_WEN);
                brd_addr = lo_w;
                brd_rd   = !dir_q;
                buf_st   = !dir_q;
                buf_req  = dir_q;
                brd_wr   = dir_q && buf_valid;
            end
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    assign busy = (state != ST_IDLE);

    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(brd_ctrl[CB_CS] && brd_ctrl[CB_HA])); // R1
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(brd_rd && brd_wr)); // R4
    AST_RD_NO_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        brd_rd |-> !brd_ctrl[CB_WEN]); // R4
    AST_WR_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        brd_wr |-> buf_req && brd_ctrl == 8'hC8); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy); // R6
    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> brd_ctrl == 8'h00 && !brd_rd && !brd_wr); // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(chip_w) && $stable(hi_w)); // R7

endmodule

// File: tb/tb_sts_sequencer.sv
module tb_sts_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir_write = 1'b0;
    logic [15:0] sector = 16'd0;
    logic        busy, done;
    logic [7:0]  brd_addr, brd_ctrl, brd_wdata, brd_rdata;
    logic        brd_rd, brd_wr;
    logic        buf_req, buf_st;
    logic [6:0]  buf_idx;
    logic        buf_valid = 1'b0;
    logic [7:0]  buf_rdata = 8'd0;
    logic [7:0]  buf_wdata;

    always #4 clk = ~clk;

    sts_sequencer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_write(dir_write),
        .sector(sector), .busy(busy), .done(done),
        .brd_addr(brd_addr), .brd_ctrl(brd_ctrl), .brd_rd(brd_rd),
        .brd_wr(brd_wr), .brd_wdata(brd_wdata), .brd_rdata(brd_rdata),
        .buf_req(buf_req), .buf_idx(buf_idx), .buf_valid(buf_valid),
        .buf_rdata(buf_rdata), .buf_st(buf_st), .buf_wdata(buf_wdata)
    );

    int n_chk = 0;
    int n_fail = 0;

    // board model: latched chip/high bytes plus address give read data
    logic [7:0] b_cs = 8'd0, b_ha = 8'd0;

    function automatic logic [7:0] pat(input logic [7:0] cs, input logic [7:0] ha,
                                       input logic [7:0] lo);
        return (lo ^ {cs[4:0], 3'b011}) + {ha[4:0], 3'b0} + 8'h5A;
    endfunction

    assign brd_rdata = pat(b_cs, b_ha, brd_addr);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // per-transfer expectations
    logic [7:0] bufmem [128];
    logic [15:0] cur_sec;
    bit          cur_dir;
    logic [7:0]  e_chip, e_hi, e_lo0;
    int k, cs_n, ha_n, done_n;
    bit wen_pre, wen_bad, prev_done, wen_addr_ok;
    int cyc = 0;

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(1'b0, "WATCHDOG", "run exceeded cycle limit", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
        if (rst_n) begin
            if (prev_done)
                check(!done && !busy, "R6", "done pulse one cycle, then idle", {done, busy}, 0);
            prev_done = done;
            if (brd_ctrl[4]) begin
                cs_n++;
                b_cs = brd_addr;
                check(brd_ctrl == 8'h98 && ha_n == 0, "R1", "chip strobe ctrl/order",
                      brd_ctrl, 8'h98);
            end
            if (brd_ctrl[5]) begin
                ha_n++;
                b_ha = brd_addr;
                check(brd_ctrl == 8'hA8 && cs_n == 1, "R2", "high strobe ctrl/order",
                      brd_ctrl, 8'hA8);
            end
            if (brd_ctrl == 8'hC8 && !brd_wr && k == 0 && !buf_req) begin
                wen_pre = 1'b1;
                wen_addr_ok = (brd_addr == e_lo0);
            end
            if (brd_ctrl[6] && !cur_dir) wen_bad = 1'b1;
            if (brd_rd) begin
                check(brd_addr == 8'(e_lo0 + k), "R3", "read low address", brd_addr, 8'(e_lo0 + k));
                check(buf_st && buf_idx == 7'(k), "R4", "store index", buf_idx, k);
                check(buf_wdata == pat(e_chip, e_hi, 8'(e_lo0 + k)), "R4", "stored byte",
                      buf_wdata, pat(e_chip, e_hi, 8'(e_lo0 + k)));
                k++;
            end
            if (brd_wr) begin
                check(brd_addr == 8'(e_lo0 + k), "R3", "write low address", brd_addr, 8'(e_lo0 + k));
                check(brd_ctrl == 8'hC8 && buf_idx == 7'(k), "R5", "write ctrl/index",
                      brd_ctrl, 8'hC8);
                check(brd_wdata == bufmem[k[6:0]], "R5", "written byte", brd_wdata, bufmem[k[6:0]]);
                k++;
            end
            if (done) begin
                done_n++;
                check(brd_ctrl == 8'h00, "R6", "ctrl cleared at done", brd_ctrl, 0);
                check(k == 128, "R3", "byte count", k, 128);
                check(cs_n == 1 && b_cs == e_chip, "R1", "chip latched", b_cs, e_chip);
                check(ha_n == 1 && b_ha == e_hi, "R9", "high latched once", ha_n, 1);
                check(b_ha == e_hi, "R2", "high address latched", b_ha, e_hi);
                if (cur_dir)
                    check(wen_pre && wen_addr_ok, "R5", "write enable before loop", wen_pre, 1);
                else
                    check(!wen_bad, "R4", "write enable stays clear", wen_bad, 0);
            end
        end
    end

    // buffer responder: random latency, one-cycle valid
    int wcnt = 0;
    always @(posedge clk) begin
        #2;
        if (buf_valid) begin
            buf_valid <= 1'b0;
            wcnt = int'($urandom % 3);
        end else if (buf_req) begin
            if (wcnt == 0) begin
                buf_valid <= 1'b1;
                buf_rdata <= bufmem[buf_idx];
            end else wcnt--;
        end
    end

    task automatic run(input logic [15:0] s, input bit w, input bit poke);
        int n;
        cur_sec = s; cur_dir = w;
        e_chip = 8'((s >> 6) & 16'h1F);
        e_hi   = 8'((s >> 1) & 16'h1F);
        e_lo0  = s[0] ? 8'h80 : 8'h00;
        k = 0; cs_n = 0; ha_n = 0; done_n = 0;
        wen_pre = 0; wen_bad = 0; wen_addr_ok = 0;
        for (int i = 0; i < 128; i++) bufmem[i] = 8'($urandom);
        @(posedge clk); #2;
        sector = s; dir_write = w; start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        if (poke) begin
            repeat (15) @(posedge clk);
            #2;
            sector = ~s; dir_write = !w; start = 1'b1;   // R7 start while busy
            @(posedge clk); #2;
            start = 1'b0;
        end
        n = 0;
        while (done_n == 0 && n < 3000) begin
            @(posedge clk); n++;
        end
        check(n < 3000, "R6", "done reached", n, 3000);
        repeat (40) @(posedge clk);
        #2;
        check(!busy && done_n == 1 && cs_n == 1, "R7", "no extra transfer", done_n, 1);
    endtask

    initial begin
        void'($urandom(32'h5EC7_0A11));
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check(brd_ctrl == 8'h00 && !busy && !done, "R8", "idle ctrl/busy/done", brd_ctrl, 0);
        check(!brd_rd && !brd_wr && !buf_req && !buf_st, "R8", "no strobes after reset",
              {brd_rd, brd_wr, buf_req, buf_st}, 0);
        run(16'h0000, 1'b0, 1'b0);
        run(16'hFFFF, 1'b1, 1'b0);
        run(16'h0041, 1'b0, 1'b0);
        run(16'h07FF, 1'b1, 1'b1);
        run(16'h0040, 1'b0, 1'b1);
        for (int t = 0; t < 8; t++)
            run(16'($urandom), 1'($urandom), 1'(t % 3 == 0));
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule